// File: doc/BRIEF.md
# Byte-to-Word Data FIFO Engine

This block sits between a host-side store of 32-bit words and a card data port that moves one byte per handshake. A transfer is set up by writing a 16-bit length register, then a control byte whose enable bit starts the transfer and whose direction bit picks the way data flows. Moving from the card, the engine gathers incoming bytes into words with the first byte in the lowest lane and pushes each finished word into the store. Moving to the card, it sends each stored word out one lane at a time, lowest lane first. A byte down-counter tracks how much of the transfer is left.

The host reads or writes the store through a plain push/pop port. Live level flags are reported per direction, and the end of a transfer is latched into sticky event bits. A transfer that cannot make progress stalls. Going to the card, that happens when the store is empty. Coming from the card, it happens when the store is full. In both cases the engine holds its card-side handshake low.

Top module: `bytepack_fifo_engine`

## Requirements
- R1: After a synchronous active-low reset the store is empty, control byte, byte counter and all sticky bits are zero, so the card handshakes are idle.
- R2: A control write stores all 8 bits of `ctl_wdata`. When bit 0 (enable) of the written value is 1, the byte counter loads from the length register. When bit 0 is 0, the counter keeps its value. Bit 1 is the direction: 1 = card to store, 0 = store to card.
- R3: Card to store: the k-th byte of a word lands in bits 8k+7..8k. When the counter reaches zero, a partial word is pushed with its unfilled upper lanes at zero.
- R4: Store to card: the head word is sent lane 0 first. It is popped after its last lane, or earlier if the counter reaches zero first.
- R5: The counter drops by one per byte handshake. `word_cnt` equals (byte_cnt + 3) >> 2.
- R6: The handshake that takes the counter to zero sets `data_end` and `block_end`. Both stay set until `evt_clr`.
- R7: While enable is 1, the counter is 0 and the store is empty, the enable bit clears on the next edge.
- R8: Flag vectors, bit 0 active, bit 1 half (half-empty on the transmit side: level <= 8; half-full on the receive side: level >= 8), bit 2 full (level 16), bit 3 empty (level 0), bit 4 available (level nonzero).
- R9: `rx_flags` is zero when direction is 0, and `tx_flags` is zero when direction is 1. Active is set when enable is 1 on the selected side.
- R10: Host pops act only when direction is 1. `host_rdata` shows the head word, or zero when the store is empty or direction is 0. A pop of an empty store changes nothing.
- R11: Host pushes act only when direction is 0. A push into a full store is dropped and sets the sticky `push_err` until `evt_clr`.
- R12: Card to store, `card_rx_ready` is low while the store is full. Store to card, `card_tx_valid` is low while the store is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| len_we | input | 1 | Length register write strobe |
| len_wdata | input | 16 | Transfer length in bytes |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control value, bit 0 enable, bit 1 direction |
| evt_clr | input | 1 | Clears data_end, block_end, push_err |
| host_push | input | 1 | Host word push |
| host_wdata | input | 32 | Word pushed by the host |
| host_pop | input | 1 | Host word pop |
| host_rdata | output | 32 | Head word, or zero |
| card_rx_valid | input | 1 | Card offers a byte |
| card_rx_data | input | 8 | Byte from the card |
| card_rx_ready | output | 1 | Engine accepts the card byte |
| card_tx_valid | output | 1 | Engine offers a byte to the card |
| card_tx_data | output | 8 | Byte to the card |
| card_tx_ready | input | 1 | Card accepts the byte |
| ctl_q | output | 8 | Stored control byte |
| byte_cnt | output | 16 | Bytes left in the transfer |
| word_cnt | output | 16 | Words left, rounded up |
| rx_flags | output | 5 | Receive-side level flags |
| tx_flags | output | 5 | Transmit-side level flags |
| data_end | output | 1 | Sticky end-of-data event |
| block_end | output | 1 | Sticky end-of-block event |
| push_err | output | 1 | Sticky dropped-push error |

## Verification
Each register write, host push or pop, and byte handshake is visible at the outputs one clock edge later. This covers counter, control byte, level flags, head word and sticky bits. The one exception is enable self-clearing, which needs a second edge after the store drains, because it follows the level update. Card-side handshake outputs are combinational from that registered state. The bench therefore drives inputs on the falling edge, samples bytes offered at that same falling edge before the consuming rising edge, and checks every other result at the first falling edge after the edge that must produce it, or at the second one for the enable clear.

// File: rtl/bfe_pkg.sv
// Shared definitions for the byte-to-word FIFO engine: flag bit
// positions and control-byte field positions.
package bfe_pkg;
    localparam int FL_ACTIVE = 0;
    localparam int FL_HALF   = 1;
    localparam int FL_FULL   = 2;
    localparam int FL_EMPTY  = 3;
    localparam int FL_AVAIL  = 4;
    localparam int FLAG_W    = 5;

    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_DIR_BIT = 1;

    typedef enum logic {
        DIR_TO_CARD   = 1'b0,
        DIR_FROM_CARD = 1'b1
    } xfer_dir_e;
endpackage

// File: rtl/bfe_store.sv
// Word store: circular buffer of DEPTH words with wrap-around pointers.
// Assumes DEPTH is a power of two. Pushes into a full store and pops
// from an empty one are dropped. The head word is read combinationally.
module bfe_store #(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int LW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] wdata,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output logic [LW-1:0]     level,
    output logic              full,
    output logic              empty
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic              do_push, do_pop;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Pointer and level tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
            case ({do_push, do_pop})
                2'b10:   level <= level + LW'(1);
                2'b01:   level <= level - LW'(1);
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/bfe_flags.sv
// Level flag generator. Both receive and transmit flag vectors come
// from one level count; the vector for the unselected direction is zero.
module bfe_flags
    import bfe_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input  logic [LW-1:0]     level,
    input  logic              dir,
    input  logic              en,
    output logic [FLAG_W-1:0] rx_flags,
    output logic [FLAG_W-1:0] tx_flags
);
    localparam logic [LW-1:0] HALF = LW'(DEPTH / 2);

    logic [FLAG_W-1:0] rx_raw, tx_raw;

    // Raw flags per side before the direction mask.
    always_comb begin
        rx_raw = '0;
        tx_raw = '0;
        rx_raw[FL_ACTIVE] = en;
        tx_raw[FL_ACTIVE] = en;
        rx_raw[FL_HALF]   = (level >= HALF);
        tx_raw[FL_HALF]   = (level <= HALF);
        rx_raw[FL_FULL]   = (level == LW'(DEPTH));
        tx_raw[FL_FULL]   = rx_raw[FL_FULL];
        rx_raw[FL_EMPTY]  = (level == '0);
        tx_raw[FL_EMPTY]  = rx_raw[FL_EMPTY];
        rx_raw[FL_AVAIL]  = (level != '0);
        tx_raw[FL_AVAIL]  = rx_raw[FL_AVAIL];
    end

    assign rx_flags = (dir == DIR_FROM_CARD) ? rx_raw : '0;
    assign tx_flags = (dir == DIR_TO_CARD)   ? tx_raw : '0;
endmodule

// File: rtl/bfe_lane.sv
// Lane sequencer: tracks which byte lane of the current word is next.
// In receive mode it accumulates bytes little-endian. In transmit mode
// it picks the lane out of the head word. word_done marks the
// handshake that closes a word, whether on the last lane or at the end
// of the transfer.
module bfe_lane #(
    parameter int WORD_W = 32,
    localparam int BYTES = WORD_W / 8,
    localparam int IDX_W = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              take,
    input  logic              dir,
    input  logic              last_byte,
    input  logic [7:0]        rx_byte,
    input  logic [WORD_W-1:0] head,
    output logic [WORD_W-1:0] pack_word,
    output logic [7:0]        tx_byte,
    output logic              word_done
);
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] acc;

    assign pack_word = acc | (WORD_W'(rx_byte) << (8 * idx));
    assign tx_byte   = head[idx*8 +: 8];
    assign word_done = take && ((idx == IDX_W'(BYTES - 1)) || last_byte);

    // Lane index and receive accumulator update.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            idx <= '0;
            acc <= '0;
        end else if (take) begin
            if (word_done) begin
                idx <= '0;
                acc <= '0;
            end else begin
                idx <= idx + IDX_W'(1);
                acc <= dir ? pack_word : '0;
            end
        end
    end
endmodule

// File: rtl/bytepack_fifo_engine.sv
// Byte-to-word FIFO engine top. Holds the length, control and byte
// counter registers, steers the store between host and card sides by
// direction, and keeps the sticky events. Assumes the card side moves
// at most one byte per cycle. If length and control are written in the
// same cycle, the counter loads the previous length.
module bytepack_fifo_engine
    import bfe_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32,
    parameter int LEN_W  = 16,
    localparam int LW    = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              len_we,
    input  logic [LEN_W-1:0]  len_wdata,
    input  logic              ctl_we,
    input  logic [7:0]        ctl_wdata,
    input  logic              evt_clr,
    input  logic              host_push,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              host_pop,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              card_rx_valid,
    input  logic [7:0]        card_rx_data,
    output logic              card_rx_ready,
    output logic              card_tx_valid,
    output logic [7:0]        card_tx_data,
    input  logic              card_tx_ready,
    output logic [7:0]        ctl_q,
    output logic [LEN_W-1:0]  byte_cnt,
    output logic [LEN_W-1:0]  word_cnt,
    output logic [FLAG_W-1:0] rx_flags,
    output logic [FLAG_W-1:0] tx_flags,
    output logic              data_end,
    output logic              block_end,
    output logic              push_err
);
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W:0]    cnt_sum;
    logic [LW-1:0]     level;
    logic              full, empty;
    logic [WORD_W-1:0] head, pack_word, st_wdata;
    logic              dir, en, live, rx_take, tx_take, take, last_byte;
    logic              word_done, st_push, st_pop, end_hit, overflow;

    assign dir       = ctl_q[CTL_DIR_BIT];
    assign en        = ctl_q[CTL_EN_BIT];
    assign live      = en && (byte_cnt != '0);
    assign last_byte = (byte_cnt == LEN_W'(1));

    assign card_rx_ready = live && (dir == DIR_FROM_CARD) && !full;
    assign card_tx_valid = live && (dir == DIR_TO_CARD) && !empty;
    assign rx_take       = card_rx_valid && card_rx_ready;
    assign tx_take       = card_tx_valid && card_tx_ready;
    assign take          = rx_take || tx_take;
    assign end_hit       = take && last_byte;

    assign st_push    = dir ? word_done : host_push;
    assign st_wdata   = dir ? pack_word : host_wdata;
    assign st_pop     = dir ? host_pop  : word_done;
    assign overflow   = host_push && !dir && full;
    assign host_rdata = (dir && !empty) ? head : '0;

    assign cnt_sum  = {1'b0, byte_cnt} + (LEN_W + 1)'(3);
    assign word_cnt = LEN_W'(cnt_sum >> 2);

    bfe_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk(clk), .rst_n(rst_n), .push(st_push), .wdata(st_wdata),
        .pop(st_pop), .head(head), .level(level), .full(full), .empty(empty)
    );

    bfe_lane #(.WORD_W(WORD_W)) u_lane (
        .clk(clk), .rst_n(rst_n), .restart(ctl_we), .take(take), .dir(dir),
        .last_byte(last_byte), .rx_byte(card_rx_data), .head(head),
        .pack_word(pack_word), .tx_byte(card_tx_data), .word_done(word_done)
    );

    bfe_flags #(.DEPTH(DEPTH)) u_flags (
        .level(level), .dir(dir), .en(en), .rx_flags(rx_flags), .tx_flags(tx_flags)
    );

    // Length, control and byte counter registers, with enable self-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q    <= '0;
            ctl_q    <= '0;
            byte_cnt <= '0;
        end else begin
            if (len_we) len_q <= len_wdata;
            if (ctl_we) begin
                ctl_q <= ctl_wdata;
                if (ctl_wdata[CTL_EN_BIT]) byte_cnt <= len_q;
            end else begin
                if (take) byte_cnt <= byte_cnt - LEN_W'(1);
                if (en && (byte_cnt == '0) && empty) ctl_q[CTL_EN_BIT] <= 1'b0;
            end
        end
    end

    // Sticky event and error bits; a set in the same cycle wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_end  <= 1'b0;
            block_end <= 1'b0;
            push_err  <= 1'b0;
        end else begin
            data_end  <= end_hit  || (data_end  && !evt_clr);
            block_end <= end_hit  || (block_end && !evt_clr);
            push_err  <= overflow || (push_err  && !evt_clr);
        end
    end
endmodule

// File: rtl/bytepack_fifo_engine_chk.sv
// Property checker for the byte-to-word FIFO engine, bound into the top.
module bytepack_fifo_engine_chk #(
    parameter int DEPTH = 16,
    parameter int LEN_W = 16,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_we,
    input logic [7:0]       ctl_q,
    input logic [LEN_W-1:0] byte_cnt,
    input logic [LW-1:0]    level,
    input logic             card_rx_valid,
    input logic             card_rx_ready,
    input logic             card_tx_valid,
    input logic             card_tx_ready,
    input logic [31:0]      host_rdata,
    input logic             data_end
);
    // R12
    rx_stall_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        card_rx_ready |-> (level < LW'(DEPTH)));

    // R12
    tx_stall_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        card_tx_valid |-> (level != '0));

    // R5
    byte_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((card_rx_valid && card_rx_ready) || (card_tx_valid && card_tx_ready)) && !ctl_we)
        |=> (byte_cnt == $past(byte_cnt) - LEN_W'(1)));

    // R6
    end_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_end) |-> ((byte_cnt == '0) || $past(ctl_we)));

    // R7
    en_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[0] && (byte_cnt == '0) && (level == '0) && !ctl_we) |=> !ctl_q[0]);

    // R10
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |-> (host_rdata == '0));

    // R8
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
endmodule

bind bytepack_fifo_engine bytepack_fifo_engine_chk #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_q(ctl_q), .byte_cnt(byte_cnt),
    .level(level), .card_rx_valid(card_rx_valid), .card_rx_ready(card_rx_ready),
    .card_tx_valid(card_tx_valid), .card_tx_ready(card_tx_ready),
    .host_rdata(host_rdata), .data_end(data_end)
);

// File: tb/bytepack_fifo_engine_bench.sv
module bytepack_fifo_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        len_we = 0, ctl_we = 0, evt_clr = 0;
    logic [15:0] len_wdata = '0;
    logic [7:0]  ctl_wdata = '0;
    logic        host_push = 0, host_pop = 0;
    logic [31:0] host_wdata = '0, host_rdata;
    logic        card_rx_valid = 0, card_rx_ready;
    logic [7:0]  card_rx_data = '0;
    logic        card_tx_valid, card_tx_ready = 0;
    logic [7:0]  card_tx_data, ctl_q;
    logic [15:0] byte_cnt, word_cnt;
    logic [4:0]  rx_flags, tx_flags;
    logic        data_end, block_end, push_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    bytepack_fifo_engine u_bytepack_fifo_engine (.*);

    // Level flag vectors: {level[4:0], expected tx_flags[4:0]}, enable off, direction 0.
    localparam logic [9:0] VEC [7] = '{
        {5'd0,  5'b01010}, {5'd1,  5'b10010}, {5'd7,  5'b10010},
        {5'd8,  5'b10010}, {5'd9,  5'b10000}, {5'd15, 5'b10000},
        {5'd16, 5'b10100}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0; tick(); rst_n = 1;
    endtask

    task automatic set_len(input logic [15:0] v);
        len_wdata = v; len_we = 1; tick(); len_we = 0;
    endtask

    task automatic set_ctl(input logic [7:0] v);
        ctl_wdata = v; ctl_we = 1; tick(); ctl_we = 0;
    endtask

    task automatic push_word(input logic [31:0] w);
        host_wdata = w; host_push = 1; tick(); host_push = 0;
    endtask

    task automatic pop_word();
        host_pop = 1; tick(); host_pop = 0;
    endtask

    task automatic feed_byte(input logic [7:0] b);
        int guard = 0;
        card_rx_data = b; card_rx_valid = 1;
        while (!card_rx_ready && guard < 50) begin tick(); guard++; end
        tick();
        card_rx_valid = 0;
    endtask

    function automatic logic [31:0] pat(input int i);
        return {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] cap [8];
        int got;
        int pushed;
        int guard;

        tick(); tick();
        rst_n = 1;
        tick();
        // R1 reset state
        chk("R1 ctl", 32'(ctl_q), 0);
        chk("R1 cnt", 32'(byte_cnt), 0);
        chk("R1 events", {29'd0, data_end, block_end, push_err}, 0);
        chk("R1 rx_ready", 32'(card_rx_ready), 0);

        // R8 R9 table walk: fill through the host port, check transmit flags
        pushed = 0;
        foreach (VEC[k]) begin
            while (pushed < int'(VEC[k][9:5])) begin push_word(pat(pushed)); pushed++; end
            chk("R8 tx_flags", 32'(tx_flags), 32'(VEC[k][4:0]));
            chk("R9 rx_flags off", 32'(rx_flags), 0);
        end

        // R11 overflow push dropped and error flagged
        push_word(32'hDEADBEEF);
        chk("R11 push_err", 32'(push_err), 1);
        chk("R11 still full", 32'(tx_flags), 32'b10100);
        // R10 pop in direction 0 ignored, reads zero
        pop_word();
        chk("R10 rdata dir0", host_rdata, 0);
        chk("R10 level kept", 32'(tx_flags), 32'b10100);

        // R2 R4 store-to-card transfer of 6 bytes
        set_len(16'd6);
        set_ctl(8'h01);
        chk("R2 ctl", 32'(ctl_q), 32'h01);
        chk("R2 cnt loaded", 32'(byte_cnt), 6);
        chk("R5 word_cnt", 32'(word_cnt), 2);
        chk("R9 tx active", 32'(tx_flags), 32'b10101);
        card_tx_ready = 1;
        got = 0; guard = 0;
        while (got < 6 && guard < 60) begin
            if (card_tx_valid) begin cap[got] = card_tx_data; got++; end
            tick(); guard++;
        end
        card_tx_ready = 0;
        for (int i = 0; i < 6; i++) chk("R4 tx byte order", 32'(cap[i]), i);
        chk("R6 data_end", 32'(data_end), 1);
        chk("R6 block_end", 32'(block_end), 1);
        chk("R5 cnt zero", 32'(byte_cnt), 0);
        chk("R7 en kept nonempty", 32'(ctl_q), 32'h01);
        chk("R4 two words popped", 32'(tx_flags), 32'b10001);
        evt_clr = 1; tick(); evt_clr = 0;
        chk("R6 clear", {29'd0, data_end, block_end, push_err}, 0);

        // R3 card-to-store transfer of 7 bytes with a partial last word
        do_reset();
        set_len(16'd7);
        set_ctl(8'h03);
        for (int i = 0; i < 7; i++) feed_byte(8'h11 + 8'(i));
        chk("R3 rx flags", 32'(rx_flags), 32'b10001);
        chk("R9 tx off", 32'(tx_flags), 0);
        chk("R6 data_end rx", 32'(data_end), 1);
        chk("R3 word0", host_rdata, 32'h14131211);
        push_word(32'hCAFEF00D);
        chk("R11 push ignored dir1", 32'(rx_flags), 32'b10001);
        chk("R11 no err dir1", 32'(push_err), 0);
        pop_word();
        chk("R3 partial word", host_rdata, 32'h00171615);
        pop_word();
        chk("R10 empty reads 0", host_rdata, 0);
        tick();
        chk("R7 en cleared", 32'(ctl_q), 32'h02);
        chk("R9 rx idle", 32'(rx_flags), 32'b01000);
        pop_word();
        chk("R10 empty pop", 32'(rx_flags), 32'b01000);

        // R12 receive stall when full
        set_len(16'd80);
        set_ctl(8'h03);
        for (int i = 0; i < 64; i++) feed_byte(8'(i));
        chk("R12 rx stalled", 32'(card_rx_ready), 0);
        chk("R8 rx full", 32'(rx_flags), 32'b10111);
        chk("R5 cnt 16", 32'(byte_cnt), 16);
        chk("R5 word_cnt 4", 32'(word_cnt), 4);
        chk("R3 first word", host_rdata, 32'h03020100);
        pop_word();
        chk("R12 rx resumes", 32'(card_rx_ready), 1);
        set_ctl(8'h02);
        chk("R2 no load", 32'(byte_cnt), 16);
        chk("R2 ctl stored", 32'(ctl_q), 32'h02);

        // R12 transmit stall when empty
        do_reset();
        set_len(16'd4);
        set_ctl(8'h01);
        card_tx_ready = 1;
        tick();
        chk("R12 tx stalled", 32'(card_tx_valid), 0);
        chk("R12 cnt held", 32'(byte_cnt), 4);
        push_word(32'hDDCCBBAA);
        got = 0; guard = 0;
        while (got < 4 && guard < 40) begin
            if (card_tx_valid) begin cap[got] = card_tx_data; got++; end
            tick(); guard++;
        end
        card_tx_ready = 0;
        chk("R4 lane0", 32'(cap[0]), 32'hAA);
        chk("R4 lane3", 32'(cap[3]), 32'hDD);
        tick();
        chk("R7 en cleared tx", 32'(ctl_q), 0);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule